// File: doc/BRIEF.md
# Hibernate Wakeup Sequencer

This block lives in an always-on domain. Each clock cycle counts as one tick of the slow real-time clock. Software starts hibernation by writing to a small register bus. While the block hibernates, the power-enable output is low and the system reset output is held low.

An external wakeup pin can end hibernation, but only after it has stayed asserted for a programmed minimum number of ticks. This rejects short glitches. Once a wakeup is accepted, power-enable rises at once. The system reset stays low for a programmed number of ticks, then it is released and the block returns to the running state.

There are three registers: a hibernate command, the filter threshold and the reset-hold length. Each length field keeps only its upper bits, so its granularity is 32 ticks.

Top module: `wake_seq`

## Requirements
- R1: After reset the block is running, so `pwr_en` = 1 and `sys_rst_n` = 1. Registers 0x24 and 0x28 read 0, and register 0x20 reads 0.
- R2: A write to address 0x20 with data bit 0 = 1 while running moves the block to hibernate on that clock edge. At the next sample, `pwr_en` = 0 and `sys_rst_n` = 0, and register 0x20 then reads 1 in bit 0. A write with bit 0 = 0 has no effect.
- R3: The filter register at 0x24 stores data bits 15:5 only. All other bits read as 0, so writing 0xFFFFFFFF reads back 0x0000FFE0.
- R4: The reset-hold register at 0x28 stores data bits 11:5 only. All other bits read as 0, so writing 0xFFFFFFFF reads back 0x00000FE0.
- R5: In hibernate, let F be the filter value. A wakeup is accepted on the (F+1)-th consecutive tick on which the synchronised pin is high. The pin passes two flops first, so `pwr_en` rises 3+F clock edges after the pin goes high.
- R6: When the synchronised pin goes low, the filter count restarts from zero. A pulse shorter than F+1 ticks causes no wakeup, and a later pulse needs the full F+1 ticks.
- R7: With F = 0, a wakeup is accepted on the first tick that sees the synchronised pin high, which is 3 edges after the pin rises.
- R8: After acceptance, `pwr_en` is 1 and `sys_rst_n` stays 0 for R+1 ticks, where R is the reset-hold value. Then `sys_rst_n` rises and the block is running, and register 0x20 reads 0.
- R9: While running, the wakeup pin has no effect on `pwr_en` or `sys_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Real-time tick clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| wake_pin | input | 1 | Asynchronous wakeup request, active high |
| pwr_en | output | 1 | Power enable for the switched domain |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
The assertions assume a write strobe lasts one cycle and carries a stable address and data. They also assume the pin only matters after it has passed the synchronizer, so the wakeup check compares against the synchronised signal and not the raw pin.

The stimulus drives bus and pin changes only on falling edges, so every change passes through the synchronizer with a known delay. It leaves the pin low before each hibernate entry and keeps glitch pulses strictly shorter than F+1 ticks. Under these conditions the expected latency and reset-hold length follow exactly from R5 and R8.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HIBER = 2'd1,
    ST_HOLD  = 2'd2
  } wake_state_e;

  localparam int unsigned OFS_HIBER = 'h20;
  localparam int unsigned OFS_FILT  = 'h24;
  localparam int unsigned OFS_HOLD  = 'h28;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/wake_filter.sv
module wake_filter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          armed,
  input  logic          pin,
  input  logic [CW-1:0] limit,
  output logic          accept
);
  logic [CW-1:0] cnt;

  // accept is combinational so the FSM can move on the same tick
  assign accept = armed && pin && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || !armed || !pin) cnt <= '0;
    else if (cnt < limit)      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          expired
);
  logic [CW-1:0] cnt;

  assign expired = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= len;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import wake_seq_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32,
  parameter int FILT_MSB    = 15,
  parameter int FILT_LSB    = 5,
  parameter int HOLD_MSB    = 11,
  parameter int HOLD_LSB    = 5,
  parameter int SYNC_STAGES = 2,
  parameter int HIBER_ADDR  = OFS_HIBER,
  parameter int FILT_ADDR   = OFS_FILT,
  parameter int HOLD_ADDR   = OFS_HOLD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wake_pin,
  output logic              pwr_en,
  output logic              sys_rst_n
);
  localparam int FW  = FILT_MSB - FILT_LSB + 1;
  localparam int HW  = HOLD_MSB - HOLD_LSB + 1;
  localparam int FCW = FILT_MSB + 1;
  localparam int HCW = HOLD_MSB + 1;

  wake_state_e   state, state_d;
  logic [FW-1:0] filt_q;
  logic [HW-1:0] hold_q;
  logic          wake_s;
  logic          accept;
  logic          expired;
  logic          hib_cmd;

  // Register writes
  assign hib_cmd = bus_we && (bus_addr == ADDR_W'(HIBER_ADDR)) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= '0;
      hold_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == ADDR_W'(FILT_ADDR)) filt_q <= bus_wdata[FILT_MSB:FILT_LSB];
      if (bus_addr == ADDR_W'(HOLD_ADDR)) hold_q <= bus_wdata[HOLD_MSB:HOLD_LSB];
    end
  end

  // Registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (bus_addr == ADDR_W'(HIBER_ADDR))
        bus_rdata[0] <= (state == ST_HIBER);
      else if (bus_addr == ADDR_W'(FILT_ADDR))
        bus_rdata[FILT_MSB:FILT_LSB] <= filt_q;
      else if (bus_addr == ADDR_W'(HOLD_ADDR))
        bus_rdata[HOLD_MSB:HOLD_LSB] <= hold_q;
    end
  end

  wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (wake_pin),
    .q   (wake_s)
  );

  wake_filter #(.CW(FCW)) u_filter (
    .clk    (clk),
    .rst    (rst),
    .armed  (state == ST_HIBER),
    .pin    (wake_s),
    .limit  ({filt_q, {FILT_LSB{1'b0}}}),
    .accept (accept)
  );

  hold_timer #(.CW(HCW)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .len     ({hold_q, {HOLD_LSB{1'b0}}}),
    .expired (expired)
  );

  // Sequencing
  always_comb begin
    state_d = state;
    case (state)
      ST_RUN:   if (hib_cmd) state_d = ST_HIBER;
      ST_HIBER: if (accept)  state_d = ST_HOLD;
      ST_HOLD:  if (expired) state_d = ST_RUN;
      default:               state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RUN;
      pwr_en    <= 1'b1;
      sys_rst_n <= 1'b1;
    end else begin
      state     <= state_d;
      pwr_en    <= (state_d != ST_HIBER);
      sys_rst_n <= (state_d == ST_RUN);
    end
  end
endmodule

// File: rtl/wake_seq_chk.sv
module wake_seq_chk #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int FILT_MSB   = 15,
  parameter int FILT_LSB   = 5,
  parameter int HIBER_ADDR = 'h20,
  parameter int FILT_ADDR  = 'h24
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              wake_s,
  input logic              pwr_en,
  input logic              sys_rst_n
);
  logic hib_wr;
  assign hib_wr = bus_we && (bus_addr == ADDR_W'(HIBER_ADDR)) && bus_wdata[0];

  a_r2_enter_hiber: assert property (@(posedge clk) disable iff (rst)
    (hib_wr && pwr_en && sys_rst_n) |=> (!pwr_en && !sys_rst_n));

  a_r3_filt_mask: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(FILT_ADDR)) |=>
      (bus_rdata[DATA_W-1:FILT_MSB+1] == '0 && bus_rdata[FILT_LSB-1:0] == '0));

  a_r5_wake_needs_pin: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_en) |-> $past(wake_s));

  a_r8_reset_under_power: assert property (@(posedge clk) disable iff (rst)
    sys_rst_n |-> pwr_en);

  a_r8_release_after_power: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_n) |-> $past(pwr_en));

  a_r9_run_holds: assert property (@(posedge clk) disable iff (rst)
    (pwr_en && sys_rst_n && !hib_wr) |=> (pwr_en && sys_rst_n));
endmodule

bind wake_seq wake_seq_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .FILT_MSB   (FILT_MSB),
  .FILT_LSB   (FILT_LSB),
  .HIBER_ADDR (HIBER_ADDR),
  .FILT_ADDR  (FILT_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .wake_s    (wake_s),
  .pwr_en    (pwr_en),
  .sys_rst_n (sys_rst_n)
);

// File: tb/wake_seq_tb.sv
module wake_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wake_pin = 1'b0;
  logic        pwr_en;
  logic        sys_rst_n;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int pin_c0 = 0;
  int rise_at = 0;
  int lat_seen = 0;
  bit mon_on = 1'b0;
  bit p_pwr, p_rst;

  typedef struct { int lat; int hold; } exp_t;
  exp_t q[$];

  wake_seq u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wake_pin  (wake_pin),
    .pwr_en    (pwr_en),
    .sys_rst_n (sys_rst_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic void chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: raise the pin, push expected latency and hold length
  task automatic wake(input int f, input int r);
    int n;
    exp_t e;
    e.lat = 3 + f; e.hold = r + 1;
    q.push_back(e);
    @(negedge clk);
    wake_pin = 1'b1;
    pin_c0 = cyc;
    n = 0;
    while (!sys_rst_n && n < 5000) begin
      @(negedge clk);
      n++;
    end
    idle(3);
    wake_pin = 1'b0;
    chk("R8 no pending wakeup", q.size(), 0);
  endtask

  // Monitor: measure each wakeup and compare against the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (!p_pwr && pwr_en) begin
        lat_seen = cyc - pin_c0;
        rise_at = cyc;
      end
      if (!p_rst && sys_rst_n) begin
        if (q.size() == 0) begin
          chk("R5 unexpected wakeup", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R5 wake latency", lat_seen, e.lat);
          chk("R8 reset hold length", cyc - rise_at, e.hold);
        end
      end
      p_pwr = pwr_en;
      p_rst = sys_rst_n;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    idle(4);
    rst = 1'b0;
    idle(1);
    p_pwr = pwr_en; p_rst = sys_rst_n; mon_on = 1'b1;

    // R1 reset state
    chk("R1 pwr_en after reset", pwr_en, 1);
    chk("R1 sys_rst_n after reset", sys_rst_n, 1);
    bus_read(6'h24, rd); chk("R1 filter reads 0", rd, 0);
    bus_read(6'h28, rd); chk("R1 hold reads 0", rd, 0);
    bus_read(6'h20, rd); chk("R1 hibernate reads 0", rd, 0);

    // R3 / R4 field masks
    bus_write(6'h24, 32'hFFFF_FFFF);
    bus_read(6'h24, rd); chk("R3 filter mask", rd, 32'h0000_FFE0);
    bus_write(6'h28, 32'hFFFF_FFFF);
    bus_read(6'h28, rd); chk("R4 hold mask", rd, 32'h0000_0FE0);

    bus_write(6'h24, 32'h40);   // F = 64
    bus_write(6'h28, 32'h20);   // R = 32

    // R9 pin ignored while running
    @(negedge clk); wake_pin = 1'b1;
    idle(10);
    chk("R9 pwr_en with pin high", pwr_en, 1);
    chk("R9 sys_rst_n with pin high", sys_rst_n, 1);
    wake_pin = 1'b0;
    idle(4);

    // R2 bit0 = 0 has no effect, bit0 = 1 enters hibernate
    bus_write(6'h20, 32'h0);
    chk("R2 zero write keeps power", pwr_en, 1);
    bus_read(6'h20, rd); chk("R2 zero write stays running", rd, 0);
    bus_write(6'h20, 32'h1);
    chk("R2 hibernate pwr_en", pwr_en, 0);
    chk("R2 hibernate sys_rst_n", sys_rst_n, 0);
    bus_read(6'h20, rd); chk("R2 hibernate readback", rd, 1);

    // R6 glitch shorter than F+1 is rejected
    @(negedge clk); wake_pin = 1'b1;
    idle(40);
    wake_pin = 1'b0;
    idle(80);
    chk("R6 glitch rejected", pwr_en, 0);

    // R5 / R8 filtered wakeup
    wake(64, 32);
    bus_read(6'h20, rd); chk("R8 running after release", rd, 0);

    // R7 zero filter
    bus_write(6'h24, 32'h0);
    bus_write(6'h28, 32'h60);   // R = 96
    bus_write(6'h20, 32'h1);
    idle(5);
    wake(0, 96);

    // R6 count restarts after a short pulse
    bus_write(6'h24, 32'h20);   // F = 32
    bus_write(6'h28, 32'h0);    // R = 0
    bus_write(6'h20, 32'h1);
    idle(5);
    @(negedge clk); wake_pin = 1'b1;
    idle(30);
    wake_pin = 1'b0;
    idle(5);
    chk("R6 short pulse no wake", pwr_en, 0);
    wake(32, 0);
    chk("R8 final sys_rst_n", sys_rst_n, 1);

    idle(5);
    finish_run();
  end
endmodule